// File: doc/BRIEF.md
# SPI Command Front End for a CAN Controller Register Space

This block is the serial slave side of a CAN controller. A host talks to it over a four-wire SPI link (mode 0, 8-bit words, most significant bit first, active-low select). The first byte after select falls is an instruction byte. Depending on that byte, the block writes, reads or masks bytes of an internal register file, restores the file to its power-up contents, or streams bytes into a transmit buffer or out of a receive buffer. In the buffer instructions the buffer number is encoded in the instruction byte itself. The register file holds the control and status bytes, the interrupt enable and flag bytes, three transmit buffers and two receive buffers.

The SPI pins are sampled in the system clock domain. SCLK must therefore stay high and low for at least four system clocks per phase. A side write port lets the surrounding receive logic, or a bench, deposit bytes into the register file, such as incoming frames for the receive buffers. An active-low interrupt output reports any enabled flag that is set. Bit timing, arbitration and the physical CAN layer are outside this block.

Top module: `can_spi_regif`

## Requirements
- R1: After reset, byte 0x0E reads 0x80 and byte 0x0F reads 0x87, so 0x0E masked with 0xEE gives 0x80 and 0x0F masked with 0x17 gives 0x07. Every other byte reads 0x00 and irq_n is high.
- R2: Instruction 0x02 is a write. The second byte is an address, and each following byte is stored at that address. The address then advances by one per byte and wraps modulo the register count.
- R3: Instruction 0x03 is a read. The second byte is an address, and the byte at that address is shifted out on MISO during the third byte, MSB first. Each further byte returns the next address.
- R4: Instruction 0x05 is a bit modify. It takes an address, a mask and a data byte. Only the bits that are 1 in the mask take the data value; the other bits keep their old value.
- R5: The one-byte instruction 0xC0 returns every register byte to its R1 value.
- R6: Instruction 0x40+2n (n = 0, 1, 2) loads transmit buffer n. The bytes that follow are written from address 0x31+0x10·n upward.
- R7: Instructions 0x90 and 0x94 read receive buffer 0 or 1. The bytes from address 0x61 (0x71 for buffer 1) upward are shifted out, starting with the byte right after the instruction. A 14-byte transfer therefore returns 13 consecutive bytes.
- R8: irq_n is low exactly when some bit is 1 in both the interrupt-enable byte 0x2B and the interrupt-flag byte 0x2C.
- R9: An instruction byte other than those of R2 to R7 changes no register, and MISO stays 0 until select rises.
- R10: A rising select ends any burst. The first byte of the next selection is decoded as a new instruction, and MISO is 0 while select is high and during bytes that return no data.
- R11: A pulse on fill_we stores fill_data at fill_addr. The byte can then be read back over SPI.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | SPI serial clock, idle low |
| spi_cs_n | input | 1 | SPI select, active low |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| fill_we | input | 1 | Side write strobe |
| fill_addr | input | ADDR_W (7) | Side write address |
| fill_data | input | 8 | Side write data |
| irq_n | output | 1 | Active-low interrupt, any enabled flag set |

## Verification
The hardest case to reach from the pins is the byte boundary during a read. The next byte's MSB has to appear on MISO after the eighth rising SCLK edge of the previous byte, and the falling edge that follows must not shift it away. The stimulus reaches this with long bursts: a 14-byte receive-buffer read and multi-byte register reads. Each byte of these holds a distinct pattern, so a lost or repeated bit at a boundary shows up as a wrong value. Unknown instructions and a soft reset in the middle of stored data are driven to show that nothing else is disturbed.

// File: rtl/can_spi_pkg.sv
package can_spi_pkg;

  localparam logic [7:0] OP_WRITE   = 8'h02;
  localparam logic [7:0] OP_READ    = 8'h03;
  localparam logic [7:0] OP_MODIFY  = 8'h05;
  localparam logic [7:0] OP_RESET   = 8'hC0;
  localparam logic [7:0] OP_LOADTX  = 8'h40;
  localparam logic [7:0] OP_READRX  = 8'h90;
  localparam int unsigned TX_OP_STEP = 2;
  localparam int unsigned RX_OP_STEP = 4;

  localparam int unsigned REG_STAT   = 'h0E;
  localparam int unsigned REG_CTRL   = 'h0F;
  localparam int unsigned REG_IE     = 'h2B;
  localparam int unsigned REG_IF     = 'h2C;
  localparam int unsigned TXB_BASE   = 'h30;
  localparam int unsigned RXB_BASE   = 'h60;
  localparam int unsigned BUF_STRIDE = 'h10;
  localparam int unsigned HDR_OFF    = 1;

  localparam logic [7:0] STAT_RST = 8'h80;
  localparam logic [7:0] CTRL_RST = 8'h87;

  typedef enum logic [2:0] {
    ST_OPC, ST_ADDR, ST_WDATA, ST_RDATA, ST_MASK, ST_MDATA, ST_IGNORE
  } cmd_state_e;

  typedef enum logic [1:0] {ACC_WR, ACC_RD, ACC_MOD} acc_e;

  function automatic logic [7:0] reg_default(input int unsigned idx);
    case (idx)
      REG_STAT: return STAT_RST;
      REG_CTRL: return CTRL_RST;
      default:  return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/can_spi_frontend.sv
module can_spi_frontend #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              csn,
  input  logic              mosi,
  output logic              miso,
  output logic              cs_act,
  output logic              byte_valid,
  output logic [WORD_W-1:0] rx_byte,
  input  logic              ld_en,
  input  logic [WORD_W-1:0] ld_data
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic sclk_m, sclk_s, sclk_d, csn_m, csn_s, mosi_m, mosi_s;
  logic rise, fall;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [WORD_W-1:0] rxs_q, rxs_d, txs_q, txs_d, rb_q, rb_d;
  logic              bv_q, bv_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_m <= 1'b0; sclk_s <= 1'b0; sclk_d <= 1'b0;
      csn_m  <= 1'b1; csn_s  <= 1'b1;
      mosi_m <= 1'b0; mosi_s <= 1'b0;
    end else begin
      sclk_m <= sclk; sclk_s <= sclk_m; sclk_d <= sclk_s;
      csn_m  <= csn;  csn_s  <= csn_m;
      mosi_m <= mosi; mosi_s <= mosi_m;
    end
  end

  assign rise   = sclk_s & ~sclk_d;
  assign fall   = ~sclk_s & sclk_d;
  assign cs_act = ~csn_s;

  always_comb begin
    cnt_d = cnt_q;
    rxs_d = rxs_q;
    txs_d = txs_q;
    rb_d  = rb_q;
    bv_d  = 1'b0;
    if (!cs_act) begin
      cnt_d = '0;
      txs_d = '0;
    end else begin
      if (rise) begin
        rxs_d = {rxs_q[WORD_W-2:0], mosi_s};
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST) begin
          bv_d = 1'b1;
          rb_d = {rxs_q[WORD_W-2:0], mosi_s};
        end
      end
      // the falling edge that closes a byte leaves the next MSB in place
      if (fall && cnt_q != '0) txs_d = {txs_q[WORD_W-2:0], 1'b0};
      if (ld_en) txs_d = ld_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0; rxs_q <= '0; txs_q <= '0; rb_q <= '0; bv_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d; rxs_q <= rxs_d; txs_q <= txs_d; rb_q <= rb_d; bv_q <= bv_d;
    end
  end

  assign miso       = txs_q[WORD_W-1];
  assign byte_valid = bv_q;
  assign rx_byte    = rb_q;

  assert_miso_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> (miso == 1'b0));
  assert_byte_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    byte_valid |=> !byte_valid);

endmodule

// File: rtl/can_spi_cmd_decoder.sv
module can_spi_cmd_decoder
  import can_spi_pkg::*;
#(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned NUM_TXB = 3,
  parameter int unsigned NUM_RXB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              byte_valid,
  input  logic [7:0]        rx_byte,
  output logic              ld_en,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic [7:0]        wr_mask,
  output logic              soft_rst
);
  cmd_state_e        state_q, state_d;
  acc_e              acc_q, acc_d;
  logic [ADDR_W-1:0] ptr_q, ptr_d, tx_start, rx_start;
  logic [7:0]        mask_q, mask_d;
  logic              tx_hit, rx_hit;

  always_comb begin
    tx_hit = 1'b0; tx_start = '0;
    for (int n = 0; n < int'(NUM_TXB); n++) begin
      if (rx_byte == 8'(OP_LOADTX + TX_OP_STEP * n)) begin
        tx_hit   = 1'b1;
        tx_start = ADDR_W'(TXB_BASE + BUF_STRIDE * n + HDR_OFF);
      end
    end
    rx_hit = 1'b0; rx_start = '0;
    for (int n = 0; n < int'(NUM_RXB); n++) begin
      if (rx_byte == 8'(OP_READRX + RX_OP_STEP * n)) begin
        rx_hit   = 1'b1;
        rx_start = ADDR_W'(RXB_BASE + BUF_STRIDE * n + HDR_OFF);
      end
    end
  end

  always_comb begin
    state_d  = state_q;
    acc_d    = acc_q;
    ptr_d    = ptr_q;
    mask_d   = mask_q;
    ld_en    = 1'b0;
    ld_addr  = ptr_q;
    wr_en    = 1'b0;
    wr_addr  = ptr_q;
    wr_data  = rx_byte;
    wr_mask  = 8'hFF;
    soft_rst = 1'b0;
    if (!cs_act) begin
      state_d = ST_OPC;
    end else if (byte_valid) begin
      case (state_q)
        ST_OPC: begin
          state_d = ST_IGNORE;
          if (rx_byte == OP_WRITE) begin
            acc_d = ACC_WR; state_d = ST_ADDR;
          end else if (rx_byte == OP_READ) begin
            acc_d = ACC_RD; state_d = ST_ADDR;
          end else if (rx_byte == OP_MODIFY) begin
            acc_d = ACC_MOD; state_d = ST_ADDR;
          end else if (rx_byte == OP_RESET) begin
            soft_rst = 1'b1;
          end else if (tx_hit) begin
            ptr_d = tx_start; state_d = ST_WDATA;
          end else if (rx_hit) begin
            ld_en = 1'b1; ld_addr = rx_start;
            ptr_d = rx_start + 1'b1; state_d = ST_RDATA;
          end
        end
        ST_ADDR: begin
          ptr_d = rx_byte[ADDR_W-1:0];
          case (acc_q)
            ACC_WR: state_d = ST_WDATA;
            ACC_RD: begin
              ld_en   = 1'b1;
              ld_addr = rx_byte[ADDR_W-1:0];
              ptr_d   = rx_byte[ADDR_W-1:0] + 1'b1;
              state_d = ST_RDATA;
            end
            default: state_d = ST_MASK;
          endcase
        end
        ST_WDATA: begin
          wr_en = 1'b1; ptr_d = ptr_q + 1'b1;
        end
        ST_RDATA: begin
          ld_en = 1'b1; ptr_d = ptr_q + 1'b1;
        end
        ST_MASK: begin
          mask_d = rx_byte; state_d = ST_MDATA;
        end
        ST_MDATA: begin
          wr_en = 1'b1; wr_mask = mask_q; state_d = ST_IGNORE;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OPC; acc_q <= ACC_WR; ptr_q <= '0; mask_q <= '0;
    end else begin
      state_q <= state_d; acc_q <= acc_d; ptr_q <= ptr_d; mask_q <= mask_d;
    end
  end

  assert_wdata_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_act && byte_valid && state_q == ST_WDATA) |=> ptr_q == ADDR_W'($past(ptr_q) + 1'b1));
  assert_ignore_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IGNORE) |-> (!wr_en && !ld_en && !soft_rst));
  assert_write_in_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> cs_act);
  assert_reset_first_byte_R5: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |-> (state_q == ST_OPC));

endmodule

// File: rtl/can_spi_regfile.sv
module can_spi_regfile
  import can_spi_pkg::*;
#(
  parameter int unsigned ADDR_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic              spi_we,
  input  logic [ADDR_W-1:0] spi_addr,
  input  logic [7:0]        spi_wdata,
  input  logic [7:0]        spi_wmask,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [7:0]        fill_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              irq_n
);
  localparam int unsigned DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] IE_IDX   = ADDR_W'(REG_IE);
  localparam logic [ADDR_W-1:0] IF_IDX   = ADDR_W'(REG_IF);
  localparam logic [ADDR_W-1:0] STAT_IDX = ADDR_W'(REG_STAT);
  localparam logic [ADDR_W-1:0] CTRL_IDX = ADDR_W'(REG_CTRL);

  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_byte
    logic [7:0] q, d;
    logic       en, fill_hit, spi_hit;
    always_comb begin
      fill_hit = fill_we && (fill_addr == ADDR_W'(i));
      spi_hit  = spi_we && (spi_addr == ADDR_W'(i));
      en       = fill_hit || spi_hit || soft_rst;
      d        = q;
      if (fill_hit) d = fill_data;
      if (spi_hit)  d = (q & ~spi_wmask) | (spi_wdata & spi_wmask);
      if (soft_rst) d = reg_default(i);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= reg_default(i);
      else if (en) q <= d;
    end
    assign mem[i] = q;
  end

  assign rd_data = mem[rd_addr];
  assign irq_n   = ~|(mem[IE_IDX] & mem[IF_IDX]);

  assert_soft_defaults_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst && !fill_we) |=> (mem[CTRL_IDX] == CTRL_RST && mem[STAT_IDX] == STAT_RST));
  assert_fill_lands_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_we && !spi_we && !soft_rst) |=> mem[$past(fill_addr)] == $past(fill_data));

endmodule

// File: rtl/can_spi_regif.sv
module can_spi_regif #(
  parameter int unsigned ADDR_W  = 7,
  parameter int unsigned NUM_TXB = 3,
  parameter int unsigned NUM_RXB = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              fill_we,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic [7:0]        fill_data,
  output logic              irq_n
);
  logic rst_m, rst_s;
  logic cs_act, byte_valid, ld_en, wr_en, soft_rst;
  logic [7:0] rx_byte, ld_data, wr_data, wr_mask;
  logic [ADDR_W-1:0] ld_addr, wr_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0; rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1; rst_s <= rst_m;
    end
  end

  can_spi_frontend #(.WORD_W(8)) u_front (
    .clk(clk), .rst_n(rst_s), .sclk(spi_sclk), .csn(spi_cs_n), .mosi(spi_mosi),
    .miso(spi_miso), .cs_act(cs_act), .byte_valid(byte_valid), .rx_byte(rx_byte),
    .ld_en(ld_en), .ld_data(ld_data)
  );

  can_spi_cmd_decoder #(.ADDR_W(ADDR_W), .NUM_TXB(NUM_TXB), .NUM_RXB(NUM_RXB)) u_dec (
    .clk(clk), .rst_n(rst_s), .cs_act(cs_act), .byte_valid(byte_valid),
    .rx_byte(rx_byte), .ld_en(ld_en), .ld_addr(ld_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_mask(wr_mask), .soft_rst(soft_rst)
  );

  can_spi_regfile #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .soft_rst(soft_rst), .spi_we(wr_en),
    .spi_addr(wr_addr), .spi_wdata(wr_data), .spi_wmask(wr_mask),
    .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .rd_addr(ld_addr), .rd_data(ld_data), .irq_n(irq_n)
  );

endmodule

// File: tb/test_can_spi_regif.sv
`timescale 1ns/1ps
module test_can_spi_regif;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0, miso, irq_n;
  logic fill_we = 1'b0;
  logic [6:0] fill_addr = '0;
  logic [7:0] fill_data = '0;
  logic [7:0] tx_b [16];
  logic [7:0] rx_b [16];
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  can_spi_regif i_can_spi_regif (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .fill_we(fill_we), .fill_addr(fill_addr), .fill_data(fill_data),
    .irq_n(irq_n)
  );

  // kind(1) addr(8) mask(8) data(8) expected(8); kind 0 = write, 1 = modify
  localparam logic [32:0] VEC [8] = '{
    {1'b0, 8'h20, 8'h00, 8'hA5, 8'hA5},
    {1'b1, 8'h20, 8'h0F, 8'h3C, 8'hAC},
    {1'b0, 8'h7F, 8'h00, 8'h5A, 8'h5A},
    {1'b1, 8'h7F, 8'hFF, 8'h00, 8'h00},
    {1'b1, 8'h7F, 8'h00, 8'hFF, 8'h00},
    {1'b0, 8'h0E, 8'h00, 8'h12, 8'h12},
    {1'b1, 8'h0E, 8'hF0, 8'hFF, 8'hF2},
    {1'b0, 8'h35, 8'h00, 8'hC3, 8'hC3}
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic spi_txn(input int n);
    @(negedge clk); cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        mosi = tx_b[i][b];
        repeat (4) @(negedge clk);
        rx_b[i][b] = miso;
        sclk = 1'b1;
        repeat (4) @(negedge clk);
        sclk = 1'b0;
      end
    end
    repeat (4) @(negedge clk);
    cs_n = 1'b1; mosi = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic rd_reg(input logic [7:0] a, output logic [7:0] v);
    tx_b[0] = 8'h03; tx_b[1] = a; tx_b[2] = 8'h00;
    spi_txn(3);
    v = rx_b[2];
  endtask

  task automatic wr_reg(input logic [7:0] a, input logic [7:0] v);
    tx_b[0] = 8'h02; tx_b[1] = a; tx_b[2] = v;
    spi_txn(3);
  endtask

  task automatic mod_reg(input logic [7:0] a, input logic [7:0] m, input logic [7:0] v);
    tx_b[0] = 8'h05; tx_b[1] = a; tx_b[2] = m; tx_b[3] = v;
    spi_txn(4);
  endtask

  task automatic fill(input logic [6:0] a, input logic [7:0] v);
    @(negedge clk); fill_we = 1'b1; fill_addr = a; fill_data = v;
    @(negedge clk); fill_we = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog R1..all actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    check("R1 irq_n after reset", {7'd0, irq_n}, 8'h01);
    check("R1 miso idle (R10)", {7'd0, miso}, 8'h00);
    rd_reg(8'h0E, v); check("R1 status 0x0E & 0xEE", v & 8'hEE, 8'h80);
    rd_reg(8'h0F, v); check("R1 control 0x0F", v, 8'h87);
    check("R1 control 0x0F & 0x17", v & 8'h17, 8'h07);
    rd_reg(8'h2C, v); check("R1 flag byte", v, 8'h00);

    // vector table: R2 write, R4 modify, R3 read back
    for (int k = 0; k < 8; k++) begin
      if (VEC[k][32]) mod_reg(VEC[k][31:24], VEC[k][23:16], VEC[k][15:8]);
      else            wr_reg(VEC[k][31:24], VEC[k][15:8]);
      rd_reg(VEC[k][31:24], v);
      check($sformatf("R2/R4 vector %0d", k), v, VEC[k][7:0]);
    end

    // R2 burst write, R3 burst read
    tx_b[0] = 8'h02; tx_b[1] = 8'h22; tx_b[2] = 8'h11; tx_b[3] = 8'h2E; tx_b[4] = 8'h93;
    spi_txn(5);
    tx_b[0] = 8'h03; tx_b[1] = 8'h22; tx_b[2] = 8'h00; tx_b[3] = 8'h00; tx_b[4] = 8'h00;
    spi_txn(5);
    check("R3 burst byte0", rx_b[2], 8'h11);
    check("R3 burst byte1", rx_b[3], 8'h2E);
    check("R3 burst byte2", rx_b[4], 8'h93);
    check("R10 miso zero during opcode", rx_b[0] | rx_b[1], 8'h00);

    // R2 wrap at top of address space
    tx_b[0] = 8'h02; tx_b[1] = 8'h7F; tx_b[2] = 8'h6B; tx_b[3] = 8'h4D;
    spi_txn(4);
    rd_reg(8'h00, v); check("R2 address wrap", v, 8'h4D);

    // R6 transmit buffer loads
    tx_b[0] = 8'h40; tx_b[1] = 8'h01; tx_b[2] = 8'h02; tx_b[3] = 8'h03; tx_b[4] = 8'h04;
    spi_txn(5);
    rd_reg(8'h31, v); check("R6 txb0 first", v, 8'h01);
    rd_reg(8'h34, v); check("R6 txb0 last", v, 8'h04);
    rd_reg(8'h35, v); check("R10 burst end leaves 0x35", v, 8'hC3);
    rd_reg(8'h30, v); check("R6 txb0 base untouched", v, 8'h00);
    tx_b[0] = 8'h42; tx_b[1] = 8'hAA; tx_b[2] = 8'hBB;
    spi_txn(3);
    rd_reg(8'h41, v); check("R6 txb1 first", v, 8'hAA);
    rd_reg(8'h42, v); check("R6 txb1 second", v, 8'hBB);
    tx_b[0] = 8'h44; tx_b[1] = 8'h77;
    spi_txn(2);
    rd_reg(8'h51, v); check("R6 txb2 first", v, 8'h77);

    // R7 / R11 receive buffers through side port
    for (int i = 0; i < 13; i++) fill(7'(8'h61 + i), 8'(8'hA0 + 7 * i));
    for (int i = 0; i < 3; i++)  fill(7'(8'h71 + i), 8'(8'h50 + i));
    tx_b[0] = 8'h90;
    for (int i = 1; i < 14; i++) tx_b[i] = 8'h00;
    spi_txn(14);
    for (int i = 1; i < 14; i++)
      check($sformatf("R7 rxb0 byte %0d (R11 fill)", i), rx_b[i], 8'(8'hA0 + 7 * (i - 1)));
    tx_b[0] = 8'h94; tx_b[1] = 8'h00; tx_b[2] = 8'h00; tx_b[3] = 8'h00;
    spi_txn(4);
    check("R7 rxb1 byte0", rx_b[1], 8'h50);
    check("R7 rxb1 byte2", rx_b[3], 8'h52);

    // R8 interrupt output
    wr_reg(8'h2C, 8'h04);
    check("R8 flag without enable", {7'd0, irq_n}, 8'h01);
    wr_reg(8'h2B, 8'h0C);
    check("R8 flag with enable", {7'd0, irq_n}, 8'h00);
    mod_reg(8'h2C, 8'h04, 8'h00);
    check("R8 flag cleared", {7'd0, irq_n}, 8'h01);

    // R9 unknown instruction
    tx_b[0] = 8'h55; tx_b[1] = 8'h20; tx_b[2] = 8'hFF; tx_b[3] = 8'hFF;
    spi_txn(4);
    check("R9 miso zero", rx_b[1] | rx_b[2] | rx_b[3], 8'h00);
    rd_reg(8'h20, v); check("R9 register unchanged", v, 8'hAC);

    // R5 soft reset
    tx_b[0] = 8'hC0;
    spi_txn(1);
    rd_reg(8'h0F, v); check("R5 control default", v, 8'h87);
    rd_reg(8'h0E, v); check("R5 status default", v, 8'h80);
    rd_reg(8'h20, v); check("R5 data cleared", v, 8'h00);
    rd_reg(8'h2B, v); check("R5 enable cleared", v, 8'h00);
    rd_reg(8'h61, v); check("R5 rx buffer cleared", v, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule